// File: doc/BRIEF.md
# Receiver Start-Up Sequencer and Protection Supervisor

This block is the digital supervisor of a resonant wireless power receiver. It brings up the receiver in order: the high-voltage linear regulator that makes the internal supply, then the 3.3 V regulator, then the converter-side ADC and serial interface, and last the step-down converter with its soft-start. Once the converter output is high enough, it moves the internal supply from the linear path to the converter path and turns off the high-voltage regulator. The regulators, comparators and converter stay in the analog domain. The block sees them only as millivolt samples and a temperature code, and it drives their enables.

Each pulse on `sample_stb` presents a new set of samples. On that pulse eleven hysteretic comparison windows update their flags. A value above a window's set level sets its flag, a value below its clear level clears it, and a value between the two leaves the flag unchanged. The flags drive a six-state machine. A reset moves the machine to `ST_OFF`. `ST_OFF` goes to `ST_BIAS` when the rectifier is present. `ST_BIAS` goes to `ST_RAIL` when the internal supply is good. `ST_RAIL` goes to `ST_READY` when the 3.3 V rail is good. `ST_READY` goes to `ST_SOFT` on a start condition. `ST_SOFT` goes to `ST_RUN` after the soft-start count. Both `ST_SOFT` and `ST_RUN` go back to `ST_READY` on a protection trip or when the enable is removed. A supply loss takes priority over every other transition:
- losing the rectifier sends any state to `ST_OFF`;
- losing the internal supply sends `ST_RAIL` and every later state to `ST_BIAS`;
- losing the 3.3 V rail sends `ST_READY` and every later state to `ST_RAIL`.

The outputs and the 8-bit status word are decoded from the state and the flags. A strobe therefore changes the flags at the clock edge that samples it, and changes the state-derived outputs one edge later.

Top module: `pwrseq_top`

## Requirements
- R1: Sampled inputs take effect only on a clock edge where `sample_stb` is high. Each window flag sets when its value is strictly above the set level, clears when its value is strictly below the clear level, and holds otherwise.
- R2: After reset, all enables and selects are low, `out_discharge` is high and `status` is 0x00.
- R3: The rectifier window sets above 4000 mV and clears below 3500 mV. While it is set, the block leaves `ST_OFF` and drives `hvldo_en` and `sel_linear`. When it clears, the block returns to `ST_OFF` from any state.
- R4: The internal-supply window sets above 3500 mV and clears below 3100 mV. It raises `ldo33_en`. When it clears, every later stage drops back to `ST_BIAS`.
- R5: The 3.3 V rail window sets above 2970 mV and clears below 2800 mV. It raises `if_ready`. When it clears, the block drops back to `ST_RAIL`.
- R6: In `ST_READY`, the converter starts (`conv_run` and `soft_start` high) when all of these hold: `en_pin` or `en_reg` is high, the rectified-OK window is set (above 6000 mV, cleared below 4500 mV), the converter-input window is set (above 5900 mV, cleared below 4500 mV), and neither the thermal nor the output over-voltage trip is active.
- R7: `soft_start` stays high for exactly SS_CYCLES clock cycles. The block then enters `ST_RUN`, which sets status bit 3 (soft-start done).
- R8: While the converter runs and the handover window is set (converter output above 4000 mV, cleared below 3500 mV), `sel_conv` is high and `sel_linear` and `hvldo_en` are low.
- R9: The clamp window sets `clamp_on` and status bit 4 when the rectified voltage is above 17500 mV. It releases them below 16000 mV. It is independent of the state.
- R10: Any of the following returns `ST_SOFT` or `ST_RUN` to `ST_READY`, with automatic restart once it clears:
  - output over-voltage (set above 5400 mV, released below 5200 mV);
  - loss of the converter-input window;
  - thermal shutdown (temperature code above 160, released below 140);
  - both enables low.
- R11: The status bits are:
  - bit 5: output over-voltage flag (set above 5500 mV, cleared below 5200 mV);
  - bit 1: rectified-OK;
  - bit 0: output-OK (set above 4500 mV, cleared below 4200 mV);
  - bits 7, 6 and 2: always zero.
- R12: `out_discharge` is high whenever the converter is not running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | Marks a new set of samples |
| vrect_mv | input | 16 | Rectified voltage, mV |
| vint_mv | input | 16 | Internal supply, mV |
| v33_mv | input | 16 | 3.3 V rail, mV |
| pvin_mv | input | 16 | Converter input, mV |
| vout_mv | input | 16 | Converter output, mV |
| temp_code | input | 8 | Die temperature, degrees C |
| en_pin | input | 1 | Converter enable from pin |
| en_reg | input | 1 | Converter enable from register |
| hvldo_en | output | 1 | High-voltage linear regulator enable |
| ldo33_en | output | 1 | 3.3 V regulator enable |
| if_ready | output | 1 | ADC and serial interface ready |
| conv_run | output | 1 | Converter running |
| soft_start | output | 1 | Converter in soft-start |
| sel_linear | output | 1 | Internal supply from linear path |
| sel_conv | output | 1 | Internal supply from converter path |
| clamp_on | output | 1 | Rectifier clamp drive |
| out_discharge | output | 1 | Converter output discharge |
| status | output | 8 | Status word |

## Verification
If a window flag is wrong, it appears on `clamp_on` or on a status bit at the edge that samples the strobe. It also appears on the enable outputs one edge later, because every output follows the flags and the state. If the state register is wrong, the enable ladder is out of order, `sel_conv` rises without `conv_run`, or status bit 3 rises without a preceding soft-start; each of these is visible in the same cycle. Soft-start length errors show one cycle after the expected `ST_RUN` entry. Hysteresis errors show only when a value is placed between the set and clear levels, so the stimulus parks values in each band.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_BIAS  = 3'd1,
        ST_RAIL  = 3'd2,
        ST_READY = 3'd3,
        ST_SOFT  = 3'd4,
        ST_RUN   = 3'd5
    } seq_state_e;

    // Window indices
    localparam int NWIN    = 11;
    localparam int W_BIAS  = 0;   // rectifier present
    localparam int W_VDD   = 1;   // internal supply good
    localparam int W_RAIL  = 2;   // 3.3 V rail good
    localparam int W_RECT  = 3;   // rectified OK for converter
    localparam int W_PVIN  = 4;   // converter input good
    localparam int W_HAND  = 5;   // output high enough for handover
    localparam int W_CLAMP = 6;   // rectifier over-voltage clamp
    localparam int W_OVPT  = 7;   // output over-voltage trip
    localparam int W_OVPS  = 8;   // output over-voltage status
    localparam int W_OUTOK = 9;   // output OK status
    localparam int W_TSD   = 10;  // thermal shutdown

endpackage

// File: rtl/pwrseq_hyst.sv
module pwrseq_hyst #(
    parameter int W         = 16,
    parameter int SET_ABOVE = 100,
    parameter int CLR_BELOW = 50
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic [W-1:0] val,
    output logic         flag
);
    localparam logic [W-1:0] SET_V = W'(SET_ABOVE);
    localparam logic [W-1:0] CLR_V = W'(CLR_BELOW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (stb) begin
            if (val > SET_V) begin
                flag <= 1'b1;
            end else if (val < CLR_V) begin
                flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pwrseq_sstimer.sv
module pwrseq_sstimer #(
    parameter int SS_CYCLES = 35000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic done
);
    localparam int            CW   = (SS_CYCLES > 1) ? $clog2(SS_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SS_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = active && (cnt == LAST);
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NWIN-1:0] flg,
    input  logic            en_any,
    input  logic            ss_done,
    output seq_state_e      state,
    output logic            hvldo_en,
    output logic            ldo33_en,
    output logic            if_ready,
    output logic            conv_run,
    output logic            soft_start,
    output logic            sel_linear,
    output logic            sel_conv,
    output logic            out_discharge,
    output logic            run_done
);
    seq_state_e nxt;
    logic       fault;
    logic       start_ok;

    always_comb begin
        fault    = flg[W_TSD] || flg[W_OVPT] || !flg[W_PVIN];
        start_ok = en_any && flg[W_RECT] && flg[W_PVIN] && !flg[W_TSD] && !flg[W_OVPT];
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= nxt;
        end
    end

    // Next state: supply losses first, then per-state advance
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF: begin
                if (flg[W_BIAS]) nxt = ST_BIAS;
            end
            ST_BIAS: begin
                if (!flg[W_BIAS])     nxt = ST_OFF;
                else if (flg[W_VDD])  nxt = ST_RAIL;
            end
            ST_RAIL: begin
                if (!flg[W_BIAS])     nxt = ST_OFF;
                else if (!flg[W_VDD]) nxt = ST_BIAS;
                else if (flg[W_RAIL]) nxt = ST_READY;
            end
            ST_READY: begin
                if (!flg[W_BIAS])      nxt = ST_OFF;
                else if (!flg[W_VDD])  nxt = ST_BIAS;
                else if (!flg[W_RAIL]) nxt = ST_RAIL;
                else if (start_ok)     nxt = ST_SOFT;
            end
            ST_SOFT: begin
                if (!flg[W_BIAS])          nxt = ST_OFF;
                else if (!flg[W_VDD])      nxt = ST_BIAS;
                else if (!flg[W_RAIL])     nxt = ST_RAIL;
                else if (fault || !en_any) nxt = ST_READY;
                else if (ss_done)          nxt = ST_RUN;
            end
            ST_RUN: begin
                if (!flg[W_BIAS])          nxt = ST_OFF;
                else if (!flg[W_VDD])      nxt = ST_BIAS;
                else if (!flg[W_RAIL])     nxt = ST_RAIL;
                else if (fault || !en_any) nxt = ST_READY;
            end
            default: nxt = ST_OFF;
        endcase
    end

    // Outputs from state and flags
    always_comb begin
        hvldo_en      = 1'b0;
        ldo33_en      = 1'b0;
        if_ready      = 1'b0;
        conv_run      = 1'b0;
        soft_start    = 1'b0;
        sel_linear    = 1'b0;
        sel_conv      = 1'b0;
        out_discharge = 1'b1;
        run_done      = 1'b0;
        unique case (state)
            ST_OFF: ;
            ST_BIAS: begin
                hvldo_en   = 1'b1;
                sel_linear = 1'b1;
            end
            ST_RAIL: begin
                hvldo_en   = 1'b1;
                sel_linear = 1'b1;
                ldo33_en   = 1'b1;
            end
            ST_READY: begin
                hvldo_en   = 1'b1;
                sel_linear = 1'b1;
                ldo33_en   = 1'b1;
                if_ready   = 1'b1;
            end
            ST_SOFT, ST_RUN: begin
                ldo33_en      = 1'b1;
                if_ready      = 1'b1;
                conv_run      = 1'b1;
                out_discharge = 1'b0;
                soft_start    = (state == ST_SOFT);
                run_done      = (state == ST_RUN);
                sel_conv      = flg[W_HAND];
                sel_linear    = !flg[W_HAND];
                hvldo_en      = !flg[W_HAND];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int MV_W         = 16,
    parameter int TEMP_W       = 8,
    parameter int SS_CYCLES    = 35000,
    parameter int BIAS_ON_MV   = 4000,
    parameter int BIAS_OFF_MV  = 3500,
    parameter int VDD_ON_MV    = 3500,
    parameter int VDD_OFF_MV   = 3100,
    parameter int RAIL_ON_MV   = 2970,
    parameter int RAIL_OFF_MV  = 2800,
    parameter int RECT_ON_MV   = 6000,
    parameter int RECT_OFF_MV  = 4500,
    parameter int PVIN_ON_MV   = 5900,
    parameter int PVIN_OFF_MV  = 4500,
    parameter int HAND_ON_MV   = 4000,
    parameter int HAND_OFF_MV  = 3500,
    parameter int CLAMP_ON_MV  = 17500,
    parameter int CLAMP_OFF_MV = 16000,
    parameter int OVPT_ON_MV   = 5400,
    parameter int OVPT_OFF_MV  = 5200,
    parameter int OVPS_ON_MV   = 5500,
    parameter int OVPS_OFF_MV  = 5200,
    parameter int OK_ON_MV     = 4500,
    parameter int OK_OFF_MV    = 4200,
    parameter int TSD_ON_C     = 160,
    parameter int TSD_OFF_C    = 140
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_stb,
    input  logic [MV_W-1:0]   vrect_mv,
    input  logic [MV_W-1:0]   vint_mv,
    input  logic [MV_W-1:0]   v33_mv,
    input  logic [MV_W-1:0]   pvin_mv,
    input  logic [MV_W-1:0]   vout_mv,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic              en_pin,
    input  logic              en_reg,
    output logic              hvldo_en,
    output logic              ldo33_en,
    output logic              if_ready,
    output logic              conv_run,
    output logic              soft_start,
    output logic              sel_linear,
    output logic              sel_conv,
    output logic              clamp_on,
    output logic              out_discharge,
    output logic [7:0]        status
);
    localparam int SET_TBL [NWIN] = '{BIAS_ON_MV, VDD_ON_MV, RAIL_ON_MV, RECT_ON_MV,
                                      PVIN_ON_MV, HAND_ON_MV, CLAMP_ON_MV, OVPT_ON_MV,
                                      OVPS_ON_MV, OK_ON_MV, TSD_ON_C};
    localparam int CLR_TBL [NWIN] = '{BIAS_OFF_MV, VDD_OFF_MV, RAIL_OFF_MV, RECT_OFF_MV,
                                      PVIN_OFF_MV, HAND_OFF_MV, CLAMP_OFF_MV, OVPT_OFF_MV,
                                      OVPS_OFF_MV, OK_OFF_MV, TSD_OFF_C};

    logic [MV_W-1:0] win_src [NWIN];
    logic [NWIN-1:0] win_flag;
    seq_state_e      state;
    logic            ss_done;
    logic            run_done;

    always_comb begin
        win_src[W_BIAS]  = vrect_mv;
        win_src[W_VDD]   = vint_mv;
        win_src[W_RAIL]  = v33_mv;
        win_src[W_RECT]  = vrect_mv;
        win_src[W_PVIN]  = pvin_mv;
        win_src[W_HAND]  = vout_mv;
        win_src[W_CLAMP] = vrect_mv;
        win_src[W_OVPT]  = vout_mv;
        win_src[W_OVPS]  = vout_mv;
        win_src[W_OUTOK] = vout_mv;
        win_src[W_TSD]   = {{(MV_W-TEMP_W){1'b0}}, temp_code};
    end

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        pwrseq_hyst #(
            .W         (MV_W),
            .SET_ABOVE (SET_TBL[i]),
            .CLR_BELOW (CLR_TBL[i])
        ) u_win (
            .clk   (clk),
            .rst_n (rst_n),
            .stb   (sample_stb),
            .val   (win_src[i]),
            .flag  (win_flag[i])
        );
    end

    pwrseq_sstimer #(.SS_CYCLES(SS_CYCLES)) u_ss (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (soft_start),
        .done   (ss_done)
    );

    pwrseq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .flg           (win_flag),
        .en_any        (en_pin || en_reg),
        .ss_done       (ss_done),
        .state         (state),
        .hvldo_en      (hvldo_en),
        .ldo33_en      (ldo33_en),
        .if_ready      (if_ready),
        .conv_run      (conv_run),
        .soft_start    (soft_start),
        .sel_linear    (sel_linear),
        .sel_conv      (sel_conv),
        .out_discharge (out_discharge),
        .run_done      (run_done)
    );

    assign clamp_on = win_flag[W_CLAMP];
    assign status   = {2'b00, win_flag[W_OVPS], win_flag[W_CLAMP], run_done,
                       1'b0, win_flag[W_RECT], win_flag[W_OUTOK]};
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sample_stb,
    input logic       en_pin,
    input logic       en_reg,
    input logic       ldo33_en,
    input logic       if_ready,
    input logic       conv_run,
    input logic       soft_start,
    input logic       sel_conv,
    input logic       clamp_on,
    input logic       out_discharge,
    input logic [7:0] status
);
    a_r6_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_run) |-> $past(en_pin || en_reg));

    a_r7_run_after_soft: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[3]) |-> $past(soft_start));

    a_r8_conv_path_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        sel_conv |-> conv_run);

    a_r5_ready_needs_rail: assert property (@(posedge clk) disable iff (!rst_n)
        if_ready |-> ldo33_en);

    a_r1_clamp_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sample_stb) |-> $stable(clamp_on));

    a_r10_stop_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_run) |-> (!status[3] && out_discharge));
endmodule

bind pwrseq_top pwrseq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sample_stb    (sample_stb),
    .en_pin        (en_pin),
    .en_reg        (en_reg),
    .ldo33_en      (ldo33_en),
    .if_ready      (if_ready),
    .conv_run      (conv_run),
    .soft_start    (soft_start),
    .sel_conv      (sel_conv),
    .clamp_on      (clamp_on),
    .out_discharge (out_discharge),
    .status        (status)
);

// File: tb/pwrseq_tb.sv
`timescale 1ns/1ps
module pwrseq_top_tb_top;
    localparam int SS = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_stb = 1'b0;
    logic [15:0] vrect_mv = '0, vint_mv = '0, v33_mv = '0, pvin_mv = '0, vout_mv = '0;
    logic [7:0]  temp_code = 8'd25;
    logic        en_pin = 1'b0, en_reg = 1'b0;
    logic        hvldo_en, ldo33_en, if_ready, conv_run, soft_start;
    logic        sel_linear, sel_conv, clamp_on, out_discharge;
    logic [7:0]  status;

    int checks = 0;
    int errors = 0;
    bit model_on = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwrseq_top #(.SS_CYCLES(SS)) dut_i (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
        .vrect_mv(vrect_mv), .vint_mv(vint_mv), .v33_mv(v33_mv),
        .pvin_mv(pvin_mv), .vout_mv(vout_mv), .temp_code(temp_code),
        .en_pin(en_pin), .en_reg(en_reg),
        .hvldo_en(hvldo_en), .ldo33_en(ldo33_en), .if_ready(if_ready),
        .conv_run(conv_run), .soft_start(soft_start), .sel_linear(sel_linear),
        .sel_conv(sel_conv), .clamp_on(clamp_on), .out_discharge(out_discharge),
        .status(status)
    );

    // Reference model: stage number, soft-start cycle count, window flags
    int m_st = 0;
    int m_cnt = 0;
    bit fb, fv, fr, frect, fp, fh, fc, fot, fos, fok, ft;

    function automatic bit hy(bit old, int v, int s, int c);
        if (v > s) return 1'b1;
        if (v < c) return 1'b0;
        return old;
    endfunction

    always @(posedge clk) begin : model
        int  nx;
        bit  en, trip, go;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0;
            {fb, fv, fr, frect, fp, fh, fc, fot, fos, fok, ft} = '0;
        end else begin
            en   = en_pin | en_reg;
            trip = ft | fot | !fp;
            go   = en && frect && fp && !ft && !fot;
            nx   = m_st;
            if (m_st > 0 && !fb)       nx = 0;
            else if (m_st > 1 && !fv)  nx = 1;
            else if (m_st > 2 && !fr)  nx = 2;
            else if (m_st == 0 && fb)  nx = 1;
            else if (m_st == 1 && fv)  nx = 2;
            else if (m_st == 2 && fr)  nx = 3;
            else if (m_st == 3 && go)  nx = 4;
            else if (m_st >= 4 && (trip || !en)) nx = 3;
            else if (m_st == 4 && m_cnt == SS - 1) nx = 5;
            if (sample_stb) begin
                fb    = hy(fb,    vrect_mv, 4000, 3500);
                fv    = hy(fv,    vint_mv,  3500, 3100);
                fr    = hy(fr,    v33_mv,   2970, 2800);
                frect = hy(frect, vrect_mv, 6000, 4500);
                fp    = hy(fp,    pvin_mv,  5900, 4500);
                fh    = hy(fh,    vout_mv,  4000, 3500);
                fc    = hy(fc,    vrect_mv, 17500, 16000);
                fot   = hy(fot,   vout_mv,  5400, 5200);
                fos   = hy(fos,   vout_mv,  5500, 5200);
                fok   = hy(fok,   vout_mv,  4500, 4200);
                ft    = hy(ft,    temp_code, 160, 140);
            end
            m_cnt = (m_st == 4) ? m_cnt + 1 : 0;
            m_st  = nx;
        end
    end

    task automatic chk(string tag, string name, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, name, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin : compare
        bit run, conv;
        if (model_on && !done) begin
            run  = (m_st >= 4);
            conv = run && fh;
            chk("R3",  "hvldo_en",      hvldo_en,      (m_st != 0) && !conv);
            chk("R4",  "ldo33_en",      ldo33_en,      m_st >= 2);
            chk("R5",  "if_ready",      if_ready,      m_st >= 3);
            chk("R6",  "conv_run",      conv_run,      run);
            chk("R7",  "soft_start",    soft_start,    m_st == 4);
            chk("R8",  "sel_linear",    sel_linear,    (m_st != 0) && !conv);
            chk("R8",  "sel_conv",      sel_conv,      conv);
            chk("R9",  "clamp_on",      clamp_on,      fc);
            chk("R12", "out_discharge", out_discharge, !run);
            chk("R7",  "status[3]",     status[3],     m_st == 5);
            chk("R9",  "status[4]",     status[4],     fc);
            chk("R11", "status[5]",     status[5],     fos);
            chk("R11", "status[1]",     status[1],     frect);
            chk("R11", "status[0]",     status[0],     fok);
            chk("R11", "status[7:6,2]", {status[7:6], status[2]}, 0);
        end
    end

    task automatic strobe();
        @(negedge clk) sample_stb = 1'b1;
        @(negedge clk) sample_stb = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_on = 1;
        @(negedge clk);
        // R2 reset state
        chk("R2", "hvldo_en", hvldo_en, 0);
        chk("R2", "out_discharge", out_discharge, 1);
        chk("R2", "status", status, 0);
        // R1 no strobe: no effect
        vrect_mv = 7000; vint_mv = 3600;
        repeat (4) @(negedge clk);
        chk("R1", "hvldo_en no strobe", hvldo_en, 0);
        vrect_mv = 5000; vint_mv = 0;
        strobe();
        chk("R3", "hvldo_en", hvldo_en, 1);
        chk("R4", "ldo33_en before vdd", ldo33_en, 0);
        vint_mv = 3600; strobe();
        chk("R4", "ldo33_en", ldo33_en, 1);
        v33_mv = 3000; strobe();
        chk("R5", "if_ready", if_ready, 1);
        en_pin = 1; strobe();
        chk("R6", "no start at low rect", conv_run, 0);
        vrect_mv = 7000; pvin_mv = 7000; strobe();
        chk("R6", "conv_run", conv_run, 1);
        chk("R7", "soft_start", soft_start, 1);
        repeat (SS) @(negedge clk);
        chk("R7", "soft done", status[3], 1);
        vout_mv = 4200; strobe();
        chk("R8", "sel_conv", sel_conv, 1);
        chk("R8", "hvldo_en off", hvldo_en, 0);
        vout_mv = 4700; strobe();
        chk("R11", "out ok", status[0], 1);
        vout_mv = 4300; strobe();
        chk("R11", "out ok held", status[0], 1);
        vout_mv = 5450; strobe();
        chk("R10", "ovp trip", conv_run, 0);
        chk("R11", "ovp status below 5500", status[5], 0);
        chk("R12", "discharge", out_discharge, 1);
        vout_mv = 5600; strobe();
        chk("R11", "ovp status", status[5], 1);
        vout_mv = 5300; strobe();
        chk("R10", "ovp trip held", conv_run, 0);
        vout_mv = 5100; strobe();
        chk("R10", "restart after ovp", conv_run, 1);
        en_pin = 0; en_reg = 1; @(negedge clk); @(negedge clk);
        chk("R6", "register enable", conv_run, 1);
        en_reg = 0; @(negedge clk); @(negedge clk);
        chk("R10", "enable removed", conv_run, 0);
        en_reg = 1; @(negedge clk); @(negedge clk);
        temp_code = 170; strobe();
        chk("R10", "thermal trip", conv_run, 0);
        temp_code = 150; strobe();
        chk("R10", "thermal held", conv_run, 0);
        temp_code = 130; strobe();
        chk("R10", "thermal release", conv_run, 1);
        pvin_mv = 5000; strobe();
        chk("R10", "pvin in band", conv_run, 1);
        pvin_mv = 4400; strobe();
        chk("R10", "pvin trip", conv_run, 0);
        pvin_mv = 5500; strobe();
        chk("R10", "pvin held", conv_run, 0);
        pvin_mv = 6000; strobe();
        chk("R10", "pvin release", conv_run, 1);
        vrect_mv = 17600; strobe();
        chk("R9", "clamp", clamp_on, 1);
        vrect_mv = 16500; strobe();
        chk("R9", "clamp held", clamp_on, 1);
        vrect_mv = 15900; strobe();
        chk("R9", "clamp release", clamp_on, 0);
        vint_mv = 3000; strobe();
        chk("R4", "vdd lost", ldo33_en, 0);
        chk("R4", "back to bias", hvldo_en, 1);
        vrect_mv = 3000; strobe();
        chk("R3", "rect lost", hvldo_en, 0);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule